// File: doc/BRIEF.md
# Dual Wiper Register Instruction Executor

This block keeps the register state behind two digitally controlled wipers and carries out decoded serial-bus instructions on it. Each wiper has a volatile 6-bit position register that drives its wiper code output, plus four 6-bit non-volatile data registers. The non-volatile registers are modelled as flip-flops preloaded at reset from a parameter. The bus front end in front of this block turns the serial traffic into strobes and hands them over: an instruction byte, an optional data byte, increment/decrement steps and a STOP. The block answers each byte with an accept or reject bit and, for reads, with a data byte. After any update to a non-volatile register it reports a busy period of configurable length.

The controller is a single state machine with these states. RECALL loads both positions from data register 0 after reset, then goes to IDLE. IDLE takes an instruction byte:
- Reads go to DONE.
- Writes go to WAIT_DATA.
- Copies into positions execute at once and go to DONE.
- Copies into data registers go to PEND.
- Increment/decrement mode goes to INCDEC.

WAIT_DATA takes the data byte. A position write then goes to DONE and a data register write goes to PEND. A STOP from IDLE, WAIT_DATA, INCDEC or DONE returns to IDLE. A STOP in PEND commits the staged update and enters PROG, unless write protect is active. PROG holds busy for the programming time and then returns to IDLE.

Top module: `wexec_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, busy is 1. After that first clock, wiper0 and wiper1 equal the reset preload of their own data register 0, and busy is 0.
- R2: The instruction byte is decoded as opcode in bits 7:4, data register select in bits 3:2, a required zero in bit 1 and the wiper select in bit 0. The following are rejected and change no register:
  - an instruction with bit 1 set;
  - any opcode other than 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010.
- R3: Opcode 1001 reads the selected position and opcode 1011 reads the selected data register. Each is accepted and returns rd_valid with the 6-bit value in rd_data bits 5:0 and zeros in bits 7:6.
- R4: Opcode 1010 followed by a data byte loads data bits 5:0 into the selected position and ignores data bits 7:6. The data byte is accepted whatever the state of wp_n.
- R5: Opcode 1100 followed by an accepted data byte changes the selected data register only at the following STOP.
- R6: Opcode 1101 copies the selected data register into its wiper's position when the instruction is accepted. Opcode 1110 copies the selected position into the selected data register of that wiper at the following STOP.
- R7: Opcode 0001 copies the selected data register of each wiper into that wiper's position at once. Opcode 1000 copies both positions into the selected data register of each wiper at the following STOP. Bit 0 is ignored by both.
- R8: After opcode 0010, each step with step_up=1 raises the selected position by one and each step with step_up=0 lowers it by one. The position saturates at 63 and 0. Steps have no effect after the STOP.
- R9: When wp_n is 0, no data register changes and busy stays 0:
  - the data byte of opcode 1100 is rejected;
  - the instruction byte of opcodes 1110 and 1000 is rejected;
  - an update whose STOP arrives with wp_n at 0 is discarded.

  Position writes are unaffected.
- R10: A STOP that commits a data register update raises busy in the next cycle and holds it for PROG_CYCLES cycles. Instruction bytes that arrive while busy is set are rejected and ignored, and a change of wp_n while busy has no effect on the update.
- R11: Every instruction or data byte gets exactly one response: ack_valid with ack in the cycle after the byte strobe. A data byte that is not expected is rejected, and so is an instruction byte before the STOP that ends the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| instr_valid | input | 1 | Instruction byte strobe |
| instr_byte | input | 8 | Instruction byte |
| data_valid | input | 1 | Data byte strobe |
| data_byte | input | 8 | Data byte, value in bits 5:0 |
| step_valid | input | 1 | Increment/decrement step strobe |
| step_up | input | 1 | Step direction, 1 up, 0 down |
| stop_strb | input | 1 | STOP condition strobe |
| wp_n | input | 1 | Write protect, 0 protects data registers |
| wiper0 | output | 6 | Position code of wiper 0 |
| wiper1 | output | 6 | Position code of wiper 1 |
| ack_valid | output | 1 | Response to a byte is present |
| ack | output | 1 | 1 accept, 0 reject |
| rd_valid | output | 1 | Read data is present |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Recall or programming in progress |

## Verification
The hardest situation to reach is protection that changes state between acceptance and commit. A data register write must be accepted while wp_n is high, have wp_n drop before its STOP, and then be shown to have left the register untouched. A second case is a wp_n drop during the programming period, which must not undo the update. The stimulus reaches both by moving wp_n between the data strobe and the STOP, and inside the busy window. Each case is then followed by a read after busy clears to bring the data register contents out through the read path.

// File: rtl/wexec_pkg.sv
package wexec_pkg;
    localparam int POT_N  = 2;
    localparam int DR_N   = 4;
    localparam int VAL_W  = 6;
    localparam int BYTE_W = 8;
    localparam int RSEL_W = $clog2(DR_N);
    localparam int PSEL_W = $clog2(POT_N);
    localparam logic [VAL_W-1:0] VAL_MAX = {VAL_W{1'b1}};

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RD_POS,
        CMD_WR_POS,
        CMD_RD_DR,
        CMD_WR_DR,
        CMD_XFR_DW,
        CMD_XFR_WD,
        CMD_GXFR_DW,
        CMD_GXFR_WD,
        CMD_INCDEC
    } cmd_e;

    typedef enum logic [2:0] {
        ST_RECALL,
        ST_IDLE,
        ST_WAIT_DATA,
        ST_INCDEC,
        ST_PEND,
        ST_DONE,
        ST_PROG
    } state_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [RSEL_W-1:0] rsel;
        logic [PSEL_W-1:0] psel;
    } instr_t;
endpackage

// File: rtl/wexec_decode.sv
module wexec_decode
    import wexec_pkg::*;
(
    input  logic [BYTE_W-1:0] ibyte,
    output instr_t            dec
);
    always_comb begin
        dec.rsel = ibyte[3:2];
        dec.psel = ibyte[0];
        unique case (ibyte[7:4])
            4'b1001: dec.cmd = CMD_RD_POS;
            4'b1010: dec.cmd = CMD_WR_POS;
            4'b1011: dec.cmd = CMD_RD_DR;
            4'b1100: dec.cmd = CMD_WR_DR;
            4'b1101: dec.cmd = CMD_XFR_DW;
            4'b1110: dec.cmd = CMD_XFR_WD;
            4'b0001: dec.cmd = CMD_GXFR_DW;
            4'b1000: dec.cmd = CMD_GXFR_WD;
            4'b0010: dec.cmd = CMD_INCDEC;
            default: dec.cmd = CMD_NONE;
        endcase
        if (ibyte[1]) dec.cmd = CMD_NONE;
    end
endmodule

// File: rtl/wexec_regs.sv
module wexec_regs
    import wexec_pkg::*;
#(
    parameter logic [POT_N*DR_N*VAL_W-1:0] DR_INIT = '0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 recall,
    input  logic [POT_N-1:0]                     w_we,
    input  logic [POT_N-1:0][VAL_W-1:0]          w_wd,
    input  logic [POT_N-1:0]                     d_we,
    input  logic [RSEL_W-1:0]                    d_sel,
    input  logic [POT_N-1:0][VAL_W-1:0]          d_wd,
    output logic [POT_N-1:0][VAL_W-1:0]          wiper,
    output logic [POT_N-1:0][DR_N-1:0][VAL_W-1:0] dr
);
    for (genvar p = 0; p < POT_N; p++) begin : g_pot
        logic [VAL_W-1:0] pos_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pos_q <= '0;
            else if (recall)    pos_q <= dr[p][0];
            else if (w_we[p])   pos_q <= w_wd[p];
        end
        assign wiper[p] = pos_q;

        for (genvar r = 0; r < DR_N; r++) begin : g_dr
            logic [VAL_W-1:0] cell_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cell_q <= DR_INIT[(p*DR_N+r)*VAL_W +: VAL_W];
                else if (d_we[p] && d_sel == RSEL_W'(r))
                    cell_q <= d_wd[p];
            end
            assign dr[p][r] = cell_q;
        end
    end
endmodule

// File: rtl/wexec_timer.sv
module wexec_timer #(
    parameter int unsigned CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= CW'(CYCLES - 1);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end
    assign last = (cnt == '0);
endmodule

// File: rtl/wexec_top.sv
module wexec_top
    import wexec_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 250000,
    parameter logic [POT_N*DR_N*VAL_W-1:0] DR_INIT =
        {6'd3, 6'd2, 6'd1, 6'd40, 6'd63, 6'd20, 6'd10, 6'd5}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [BYTE_W-1:0] instr_byte,
    input  logic              data_valid,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              step_valid,
    input  logic              step_up,
    input  logic              stop_strb,
    input  logic              wp_n,
    output logic [VAL_W-1:0]  wiper0,
    output logic [VAL_W-1:0]  wiper1,
    output logic              ack_valid,
    output logic              ack,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy
);
    state_e state, nxt;
    instr_t dec, ctx;
    logic   ctx_ld;

    logic [POT_N-1:0]                      w_we, d_we;
    logic [POT_N-1:0][VAL_W-1:0]           w_wd, wiper;
    logic [POT_N-1:0][DR_N-1:0][VAL_W-1:0] dr;
    logic                                  recall, timer_load, timer_last;

    logic [POT_N-1:0]            stg_mask, stg_mask_n;
    logic [POT_N-1:0][VAL_W-1:0] stg_val, stg_val_n;
    logic [RSEL_W-1:0]           stg_sel, stg_sel_n;
    logic                        stg_ld;

    logic              rsp_v, rsp_ack, rsp_rd;
    logic [BYTE_W-1:0] rsp_dat;
    logic [VAL_W-1:0]  cur;

    wexec_decode u_dec (.ibyte(instr_byte), .dec(dec));

    wexec_regs #(.DR_INIT(DR_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .recall(recall),
        .w_we(w_we), .w_wd(w_wd),
        .d_we(d_we), .d_sel(stg_sel), .d_wd(stg_val),
        .wiper(wiper), .dr(dr)
    );

    wexec_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .last(timer_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RECALL;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        ctx_ld     = 1'b0;
        recall     = 1'b0;
        timer_load = 1'b0;
        w_we       = '0;
        w_wd       = wiper;
        d_we       = '0;
        stg_ld     = 1'b0;
        stg_mask_n = '0;
        stg_val_n  = wiper;
        stg_sel_n  = dec.rsel;
        rsp_v      = instr_valid || data_valid;
        rsp_ack    = 1'b0;
        rsp_rd     = 1'b0;
        rsp_dat    = '0;
        cur        = wiper[ctx.psel];

        unique case (state)
            ST_RECALL: begin
                recall = 1'b1;
                nxt    = ST_IDLE;
            end
            ST_IDLE: begin
                if (instr_valid && dec.cmd != CMD_NONE) begin
                    ctx_ld  = 1'b1;
                    rsp_ack = 1'b1;
                    nxt     = ST_DONE;
                    unique case (dec.cmd)
                        CMD_RD_POS: begin
                            rsp_rd  = 1'b1;
                            rsp_dat = BYTE_W'(wiper[dec.psel]);
                        end
                        CMD_RD_DR: begin
                            rsp_rd  = 1'b1;
                            rsp_dat = BYTE_W'(dr[dec.psel][dec.rsel]);
                        end
                        CMD_WR_POS, CMD_WR_DR: nxt = ST_WAIT_DATA;
                        CMD_XFR_DW: begin
                            w_we[dec.psel] = 1'b1;
                            w_wd[dec.psel] = dr[dec.psel][dec.rsel];
                        end
                        CMD_GXFR_DW: begin
                            for (int p = 0; p < POT_N; p++) begin
                                w_we[p] = 1'b1;
                                w_wd[p] = dr[p][dec.rsel];
                            end
                        end
                        CMD_XFR_WD, CMD_GXFR_WD: begin
                            if (wp_n) begin
                                stg_ld = 1'b1;
                                if (dec.cmd == CMD_XFR_WD)
                                    stg_mask_n[dec.psel] = 1'b1;
                                else
                                    stg_mask_n = '1;
                                nxt = ST_PEND;
                            end else begin
                                rsp_ack = 1'b0;
                            end
                        end
                        CMD_INCDEC: nxt = ST_INCDEC;
                        default: begin
                            rsp_ack = 1'b0;
                            nxt     = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_WAIT_DATA: begin
                if (data_valid) begin
                    nxt = ST_DONE;
                    if (ctx.cmd == CMD_WR_POS) begin
                        rsp_ack         = 1'b1;
                        w_we[ctx.psel]  = 1'b1;
                        w_wd[ctx.psel]  = data_byte[VAL_W-1:0];
                    end else if (wp_n) begin
                        rsp_ack                  = 1'b1;
                        stg_ld                   = 1'b1;
                        stg_sel_n                = ctx.rsel;
                        stg_mask_n[ctx.psel]     = 1'b1;
                        stg_val_n[ctx.psel]      = data_byte[VAL_W-1:0];
                        nxt                      = ST_PEND;
                    end
                end
            end
            ST_INCDEC: begin
                if (step_valid) begin
                    w_we[ctx.psel] = 1'b1;
                    if (step_up) w_wd[ctx.psel] = (cur == VAL_MAX) ? cur : cur + 1'b1;
                    else         w_wd[ctx.psel] = (cur == '0) ? cur : cur - 1'b1;
                end
            end
            ST_PEND, ST_DONE: ;
            ST_PROG: begin
                if (timer_last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase

        if (stop_strb && state != ST_RECALL && state != ST_PROG) begin
            if (state == ST_PEND && wp_n) begin
                d_we       = stg_mask;
                timer_load = 1'b1;
                nxt        = ST_PROG;
            end else begin
                nxt = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx       <= '{cmd: CMD_NONE, rsel: '0, psel: '0};
            stg_mask  <= '0;
            stg_val   <= '0;
            stg_sel   <= '0;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (ctx_ld) ctx <= dec;
            if (stg_ld) begin
                stg_mask <= stg_mask_n;
                stg_val  <= stg_val_n;
                stg_sel  <= stg_sel_n;
            end
            ack_valid <= rsp_v;
            ack       <= rsp_ack;
            rd_valid  <= rsp_rd;
            if (rsp_rd) rd_data <= rsp_dat;
        end
    end

    assign wiper0 = wiper[0];
    assign wiper1 = wiper[1];
    assign busy   = (state == ST_RECALL) || (state == ST_PROG);
endmodule

// File: rtl/wexec_chk.sv
module wexec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic       data_valid,
    input logic       ack_valid,
    input logic       ack,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic [5:0] wiper0,
    input logic [5:0] wiper1
);
    a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && instr_valid) |=> (ack_valid && !ack));

    a_r10_busy_wipers_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(wiper0) && $stable(wiper1)));

    a_r11_resp_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(instr_valid || data_valid));

    a_r11_read_is_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (ack_valid && ack));

    a_r3_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[7:6] == 2'b00));
endmodule

bind wexec_top wexec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .data_valid(data_valid),
    .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .wiper0(wiper0), .wiper1(wiper1)
);

// File: tb/tb_wexec_top.sv
`timescale 1ns/1ps
module tb_wexec_top;
    localparam int PROG = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0, data_valid = 1'b0;
    logic [7:0] instr_byte = '0, data_byte = '0;
    logic       step_valid = 1'b0, step_up = 1'b0, stop_strb = 1'b0, wp_n = 1'b1;
    logic [5:0] wiper0, wiper1;
    logic       ack_valid, ack, rd_valid, busy;
    logic [7:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    wexec_top #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_byte(instr_byte),
        .data_valid(data_valid), .data_byte(data_byte), .step_valid(step_valid),
        .step_up(step_up), .stop_strb(stop_strb), .wp_n(wp_n), .wiper0(wiper0),
        .wiper1(wiper1), .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) begin
                chk("R11 response without pending byte", 1, 0);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " ack"}, ack, e[9]);
                chk({t, " rd_valid"}, rd_valid, e[8]);
                if (e[8]) chk({t, " rd_data"}, rd_data, e[7:0]);
            end
        end
    end

    task automatic instr(logic [7:0] b, bit a, bit rd, logic [7:0] v, string tag);
        @(negedge clk);
        instr_byte = b; instr_valid = 1'b1;
        exp_q.push_back({a, rd, v}); tag_q.push_back(tag);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic dbyte(logic [7:0] b, bit a, string tag);
        @(negedge clk);
        data_byte = b; data_valid = 1'b1;
        exp_q.push_back({a, 1'b0, 8'h00}); tag_q.push_back(tag);
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk); stop_strb = 1'b1;
        @(negedge clk); stop_strb = 1'b0;
    endtask

    task automatic step(bit up);
        @(negedge clk); step_valid = 1'b1; step_up = up;
        @(negedge clk); step_valid = 1'b0;
    endtask

    task automatic wait_prog();
        repeat (PROG) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            chk("watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 recall wiper0", wiper0, 5);
        chk("R1 recall wiper1", wiper1, 40);
        chk("R1 busy clear", busy, 0);

        // R3 reads
        instr(8'h90, 1, 1, 8'd5, "R3 read pos0"); stop();
        instr(8'h91, 1, 1, 8'd40, "R3 read pos1"); stop();
        instr(8'hBC, 1, 1, 8'd63, "R3 read dr0.3"); stop();
        instr(8'hB9, 1, 1, 8'd2, "R3 read dr1.2");
        dbyte(8'h11, 0, "R11 unexpected data"); stop();

        // R4 position write under protection, upper bits dropped
        wp_n = 1'b0;
        instr(8'hA1, 1, 0, 0, "R4 write pos1 instr");
        dbyte(8'hDF, 1, "R4 write pos1 data");
        chk("R4 wiper1 value", wiper1, 31); stop();
        wp_n = 1'b1;

        // R2 rejected encodings
        instr(8'h30, 0, 0, 0, "R2 unlisted opcode"); stop();
        instr(8'h92, 0, 0, 0, "R2 bit1 set"); stop();
        instr(8'hD6, 0, 0, 0, "R2 xfer with bit1 set"); stop();
        chk("R2 wiper0 unchanged", wiper0, 5);
        chk("R2 wiper1 unchanged", wiper1, 31);

        // R5 / R10 data register write deferred to STOP
        instr(8'hC4, 1, 0, 0, "R5 write dr0.1 instr");
        dbyte(8'h15, 1, "R5 write dr0.1 data");
        instr(8'h90, 0, 0, 0, "R11 instr before STOP");
        chk("R5 no busy before STOP", busy, 0);
        stop();
        chk("R10 busy after STOP", busy, 1);
        instr(8'h90, 0, 0, 0, "R10 instr during busy");
        wp_n = 1'b0;
        repeat (PROG - 3) @(negedge clk);
        chk("R10 busy last cycle", busy, 1);
        @(negedge clk);
        chk("R10 busy ends", busy, 0);
        wp_n = 1'b1;
        instr(8'hB4, 1, 1, 8'd21, "R5 R10 read dr0.1 after program"); stop();

        // R6 single transfers
        instr(8'hD4, 1, 0, 0, "R6 xfer dr0.1 to pos0");
        chk("R6 wiper0 from dr", wiper0, 21); stop();
        chk("R6 volatile xfer no busy", busy, 0);
        instr(8'hA0, 1, 0, 0, "R6 write pos0"); dbyte(8'd50, 1, "R6 write pos0 data"); stop();
        instr(8'hE8, 1, 0, 0, "R6 xfer pos0 to dr0.2"); stop();
        chk("R6 busy after pos-to-dr", busy, 1);
        wait_prog();
        instr(8'hB8, 1, 1, 8'd50, "R6 read dr0.2"); stop();

        // R7 gang transfers
        instr(8'h1C, 1, 0, 0, "R7 gang dr3 to pos");
        chk("R7 gang wiper0", wiper0, 63);
        chk("R7 gang wiper1", wiper1, 3); stop();
        instr(8'h81, 1, 0, 0, "R7 gang pos to dr0"); stop();
        wait_prog();
        instr(8'hB0, 1, 1, 8'd63, "R7 read dr0.0"); stop();
        instr(8'hB1, 1, 1, 8'd3, "R7 read dr1.0"); stop();

        // R8 increment / decrement with saturation
        instr(8'h21, 1, 0, 0, "R8 incdec pos1");
        for (int i = 0; i < 5; i++) step(1'b0);
        chk("R8 saturate at 0", wiper1, 0);
        step(1'b1); step(1'b1);
        chk("R8 up two", wiper1, 2);
        chk("R8 other wiper untouched", wiper0, 63);
        stop();
        instr(8'h20, 1, 0, 0, "R8 incdec pos0");
        step(1'b1);
        chk("R8 saturate at 63", wiper0, 63);
        step(1'b0);
        chk("R8 down one", wiper0, 62);
        stop();
        step(1'b0);
        chk("R8 step after STOP ignored", wiper0, 62);

        // R9 write protection
        wp_n = 1'b0;
        instr(8'hC0, 1, 0, 0, "R9 write dr instr");
        dbyte(8'h07, 0, "R9 write dr data rejected"); stop();
        chk("R9 no busy when protected", busy, 0);
        instr(8'hE0, 0, 0, 0, "R9 pos-to-dr rejected"); stop();
        instr(8'h80, 0, 0, 0, "R9 gang pos-to-dr rejected"); stop();
        wp_n = 1'b1;
        instr(8'hC0, 1, 0, 0, "R9 write dr instr late protect");
        dbyte(8'h07, 1, "R9 write dr data accepted");
        wp_n = 1'b0;
        stop();
        chk("R9 discarded at STOP no busy", busy, 0);
        wp_n = 1'b1;
        instr(8'hB0, 1, 1, 8'd63, "R9 dr0.0 unchanged"); stop();
        instr(8'hB1, 1, 1, 8'd3, "R9 dr1.0 unchanged"); stop();

        repeat (3) @(negedge clk);
        chk("R11 all responses seen", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule